// File: doc/BRIEF.md
# Gated Timebase Counter with Prescaler

This block is a free-running timebase counter that can be clocked in one of two ways. In gate mode, a fixed system-clock/8 tick advances the counter only while an external timer pin is high. In external-clock mode, the pin first goes through a two-stage synchronizer and a level filter, and each accepted rising edge becomes one tick. In both modes a 2-bit prescaler divides the selected tick before it reaches the counter. The counter wraps to zero and gives a one-cycle overflow pulse at each wrap.

A one-byte configuration register sits on a simple write-strobe bus and can always be read back. It holds the mode bit, the prescaler code and a select bit for a companion tick output (system clock /32 or /4). It also holds two bits that can be written only once after reset: an enable/compatibility bit and an emulation bit. The emulation bit takes its reset value from a strap input. A stop request sets a read-only flag and freezes the counter while it stays set.

Top module: `gated_timebase`

## Requirements
- R1: With the mode bit (register bit 0) at 1 and the pin held high, the counter advances once every 8·2^p system clocks, where p is the prescaler code in register bits 2:1.
- R2: In gate mode with the pin low, the counter does not advance.
- R3: With the mode bit at 0, each rising edge of the filtered pin is one tick into the prescaler.
- R4: The filter accepts a new pin level only after it has been seen for 3 consecutive clocks after synchronization. A level that lasts 2 clocks produces no tick.
- R5: Prescaler codes 00, 01, 10 and 11 divide the selected tick by 1, 2, 4 and 8.
- R6: With register bit 3 at 0, comp_tick_o pulses once every 32 clocks. With bit 3 at 1, it pulses once every 4 clocks.
- R7: Register bit 5 (enable/compatibility) resets to 1. The first register write after reset sets it, and later writes leave it unchanged.
- R8: Register bit 4 (emulation) resets to the inverse of strap_i. The first register write after reset sets it, and later writes leave it unchanged.
- R9: Register bit 6 reads 1 while a stop request holds the block and 0 while it runs. While it is 1, the counter keeps its value.
- R10: The counter wraps from all-ones to zero. ovf_o is high for exactly the one cycle in which the counter reads zero after the wrap.
- R11: Any change of the prescaler code or the mode clears the prescaler's partial count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | External timer pin (gate or clock source) |
| strap_i | input | 1 | Strap that sets the emulation bit's reset value |
| stop_req_i | input | 1 | Stop request, level sensitive |
| reg_we_i | input | 1 | Configuration write strobe |
| reg_wdata_i | input | 8 | Configuration write data |
| reg_rdata_o | output | 8 | Configuration read data |
| cnt_o | output | CNT_W | Timebase count |
| ovf_o | output | 1 | One-cycle wrap pulse |
| comp_tick_o | output | 1 | Companion prescaler tick |

## Verification
The bench measures count increments over windows that are exact multiples of the expected tick period, for every prescaler code in both modes. A wrong divide ratio, a gate that leaks while the pin is low, or an off-by-one divider therefore shows up as a wrong delta. The bench drives 2-clock pin pulses, which a filter that is too short would count, and 3-clock pulses, which a filter that is too long would drop. It leaves the prescaler part-way through a count and then changes the code. A prescaler that keeps its old partial count would then either miss the expected increment or never reach it. For the write-once bits, the bench writes twice and reads back: the second write must be ignored while the ordinary fields still update. The bench also takes the emulation bit's reset value under both strap levels.

// File: rtl/gtb_pkg.sv
package gtb_pkg;
  localparam int REG_W    = 8;
  localparam int PSC_W    = 2;
  localparam int B_GATE   = 0;
  localparam int B_PSC    = 1;
  localparam int B_CFAST  = 3;
  localparam int B_EMU    = 4;
  localparam int B_COMPAT = 5;
  localparam int B_STOP   = 6;

  typedef struct packed {
    logic             comp_fast;
    logic [PSC_W-1:0] psc;
    logic             gate;
  } cfg_t;
endpackage

// File: rtl/gtb_regs.sv
module gtb_regs
  import gtb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strap_i,
  input  logic             stop_req_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output cfg_t             cfg_o,
  output logic             stop_o
);
  cfg_t cfg_q;
  logic emu_q, compat_q, lock_q, stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      emu_q    <= ~strap_i;
      compat_q <= 1'b1;
      lock_q   <= 1'b0;
      stop_q   <= 1'b0;
    end else begin
      stop_q <= stop_req_i;
      if (we_i) begin
        cfg_q.gate      <= wdata_i[B_GATE];
        cfg_q.psc       <= wdata_i[B_PSC +: PSC_W];
        cfg_q.comp_fast <= wdata_i[B_CFAST];
        lock_q          <= 1'b1;
        if (!lock_q) begin
          emu_q    <= wdata_i[B_EMU];
          compat_q <= wdata_i[B_COMPAT];
        end
      end
    end
  end

  always_comb begin
    rdata_o                  = '0;
    rdata_o[B_GATE]          = cfg_q.gate;
    rdata_o[B_PSC +: PSC_W]  = cfg_q.psc;
    rdata_o[B_CFAST]         = cfg_q.comp_fast;
    rdata_o[B_EMU]           = emu_q;
    rdata_o[B_COMPAT]        = compat_q;
    rdata_o[B_STOP]          = stop_q;
  end

  assign cfg_o  = cfg_q;
  assign stop_o = stop_q;

  p_compat_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && we_i) |=> $stable(compat_q));
  p_emu_once_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && we_i) |=> $stable(emu_q));
endmodule

// File: rtl/gtb_tick_src.sv
module gtb_tick_src #(
  parameter int FILT_LEN  = 3,
  parameter int GATE_DIV  = 8,
  parameter int COMP_SLOW = 32,
  parameter int COMP_FAST = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic gate_mode_i,
  input  logic comp_fast_i,
  output logic tick_o,
  output logic comp_tick_o
);
  localparam int FW = $clog2(FILT_LEN + 1);
  localparam int GW = $clog2(GATE_DIV);
  localparam int CW = $clog2(COMP_SLOW);

  logic [1:0]    sync_q;
  logic          filt_q, filt_d;
  logic [FW-1:0] run_q;
  logic [GW-1:0] gdiv_q;
  logic [CW-1:0] cdiv_q;
  logic          edge_s, gate_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      filt_q <= 1'b0;
      filt_d <= 1'b0;
      run_q  <= '0;
      gdiv_q <= '0;
      cdiv_q <= '0;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      filt_d <= filt_q;
      // level must differ for FILT_LEN samples in a row
      if (sync_q[1] == filt_q) run_q <= '0;
      else if (run_q == FW'(FILT_LEN - 1)) begin
        filt_q <= sync_q[1];
        run_q  <= '0;
      end else run_q <= run_q + 1'b1;
      gdiv_q <= (gdiv_q == GW'(GATE_DIV - 1)) ? '0 : gdiv_q + 1'b1;
      cdiv_q <= (cdiv_q == CW'(COMP_SLOW - 1)) ? '0 : cdiv_q + 1'b1;
    end
  end

  assign edge_s = filt_q & ~filt_d;
  assign gate_s = (gdiv_q == GW'(GATE_DIV - 1)) & sync_q[1];
  assign tick_o = gate_mode_i ? gate_s : edge_s;
  assign comp_tick_o = comp_fast_i
    ? ((cdiv_q & CW'(COMP_FAST - 1)) == CW'(COMP_FAST - 1))
    : (cdiv_q == CW'(COMP_SLOW - 1));

  p_edge_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_s |=> !edge_s);
  p_filter_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_q[1] == filt_q) |=> $stable(filt_q));
endmodule

// File: rtl/gtb_presc.sv
module gtb_presc #(
  parameter int PSC_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic             mode_i,
  output logic             tick_o
);
  localparam int PC_W = (1 << PSC_W) - 1;

  logic [PC_W-1:0]  pcnt_q, limit;
  logic [PSC_W-1:0] psc_d;
  logic             mode_d, chg;

  assign limit = PC_W'((32'd1 << psc_i) - 32'd1);
  assign chg   = (psc_i != psc_d) || (mode_i != mode_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      psc_d  <= '0;
      mode_d <= 1'b0;
    end else begin
      psc_d  <= psc_i;
      mode_d <= mode_i;
      if (chg) pcnt_q <= '0;
      else if (tick_i) pcnt_q <= (pcnt_q == limit) ? '0 : pcnt_q + 1'b1;
    end
  end

  assign tick_o = tick_i & ~chg & (pcnt_q == limit);

  p_pcnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chg |-> (pcnt_q <= limit));
  p_chg_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg |=> (pcnt_q == '0));
endmodule

// File: rtl/gtb_counter.sv
module gtb_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hold_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q, adv;

  assign adv = tick_i & ~hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (adv) cnt_q <= cnt_q + 1'b1;
      ovf_q <= adv & (&cnt_q);
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  p_hold_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_q == $past(cnt_q)));
  p_ovf_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> (cnt_q == '0));
  p_ovf_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> !ovf_q);
endmodule

// File: rtl/gated_timebase.sv
module gated_timebase
  import gtb_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int FILT_LEN  = 3,
  parameter int GATE_DIV  = 8,
  parameter int COMP_SLOW = 32,
  parameter int COMP_FAST = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             strap_i,
  input  logic             stop_req_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             comp_tick_o
);
  cfg_t cfg;
  logic stop_s, base_tick, div_tick;

  gtb_regs u_regs (
    .clk_i, .rst_ni, .strap_i, .stop_req_i,
    .we_i(reg_we_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .cfg_o(cfg), .stop_o(stop_s)
  );

  gtb_tick_src #(
    .FILT_LEN(FILT_LEN), .GATE_DIV(GATE_DIV),
    .COMP_SLOW(COMP_SLOW), .COMP_FAST(COMP_FAST)
  ) u_src (
    .clk_i, .rst_ni, .pin_i,
    .gate_mode_i(cfg.gate), .comp_fast_i(cfg.comp_fast),
    .tick_o(base_tick), .comp_tick_o
  );

  gtb_presc #(.PSC_W(PSC_W)) u_presc (
    .clk_i, .rst_ni, .tick_i(base_tick),
    .psc_i(cfg.psc), .mode_i(cfg.gate), .tick_o(div_tick)
  );

  gtb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(div_tick), .hold_i(stop_s),
    .cnt_o, .ovf_o
  );
endmodule

// File: tb/gated_timebase_tb_top.sv
`timescale 1ns/1ps
module gated_timebase_tb_top;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pin = 1'b0, strap = 1'b1, stop_req = 1'b0;
  logic          we = 1'b0;
  logic [7:0]    wdata = '0, rdata;
  logic [CW-1:0] cnt;
  logic          ovf, ctick;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  gated_timebase #(.CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .strap_i(strap),
    .stop_req_i(stop_req), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .cnt_o(cnt), .ovf_o(ovf), .comp_tick_o(ctick)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk); rst_n = 1'b0; strap = s;
    cyc(3); rst_n = 1'b1; cyc(2);
  endtask

  task automatic ext_edges(input int n);
    for (int i = 0; i < n; i++) begin
      pin = 1'b1; cyc(6); pin = 1'b0; cyc(6);
    end
  endtask

  task automatic t_reset_once;
    do_reset(1'b1);
    chk("R7/R8 reset reg strap=1", rdata, 8'h20);
    chk("R10 reset cnt", cnt, 0);
    chk("R10 reset ovf", ovf, 0);
    wr(8'h10);
    chk("R7/R8 first write", rdata, 8'h10);
    wr(8'h24);
    chk("R7/R8 second write ignored", rdata, 8'h14);
    do_reset(1'b0);
    chk("R8 reset reg strap=0", rdata, 8'h30);
    wr(8'h00);
    wr(8'h30);
    chk("R7/R8 lock after clear", rdata, 8'h00);
  endtask

  task automatic t_gate(input int p);
    int c0;
    pin = 1'b1;
    wr(8'(1 | (p << 1)));
    cyc(40); c0 = cnt;
    cyc(4 * (8 << p));
    chk($sformatf("R1/R5 gate psc=%0d", p), (cnt - c0) & 8'hFF, 4);
  endtask

  task automatic t_gate_low;
    int c0;
    pin = 1'b0; wr(8'h01); cyc(20); c0 = cnt;
    cyc(300);
    chk("R2 gate low", (cnt - c0) & 8'hFF, 0);
  endtask

  task automatic t_ext(input int p);
    int c0;
    pin = 1'b0; cyc(10);
    wr(8'(p << 1)); cyc(20); c0 = cnt;
    ext_edges(16); cyc(12);
    chk($sformatf("R3/R5 ext psc=%0d", p), (cnt - c0) & 8'hFF, 16 >> p);
  endtask

  task automatic t_glitch;
    int c0;
    pin = 1'b0; wr(8'h00); cyc(20); c0 = cnt;
    for (int i = 0; i < 5; i++) begin
      pin = 1'b1; cyc(2); pin = 1'b0; cyc(6);
    end
    cyc(10);
    chk("R4 two-clock pulses rejected", (cnt - c0) & 8'hFF, 0);
    pin = 1'b1; cyc(3); pin = 1'b0; cyc(16);
    chk("R4 three-clock pulse accepted", (cnt - c0) & 8'hFF, 1);
  endtask

  task automatic t_phase;
    int c0;
    pin = 1'b0; wr(8'h06); cyc(20); c0 = cnt;
    ext_edges(5); cyc(10);
    chk("R11 partial /8", (cnt - c0) & 8'hFF, 0);
    wr(8'h02); cyc(5);
    ext_edges(1); cyc(10);
    chk("R11 first edge after change", (cnt - c0) & 8'hFF, 0);
    ext_edges(1); cyc(10);
    chk("R11 second edge after change", (cnt - c0) & 8'hFF, 1);
  endtask

  task automatic t_comp(input logic fast);
    int n = 0;
    wr(fast ? 8'h08 : 8'h00); cyc(5);
    for (int i = 0; i < 128; i++) begin
      @(negedge clk); if (ctick) n++;
    end
    chk(fast ? "R6 comp /4" : "R6 comp /32", n, fast ? 32 : 4);
  endtask

  task automatic t_stop;
    int c0;
    pin = 1'b1; wr(8'h01); cyc(20);
    stop_req = 1'b1; cyc(3);
    chk("R9 stop flag set", (rdata >> 6) & 1, 1);
    c0 = cnt; cyc(100);
    chk("R9 counter held", (cnt - c0) & 8'hFF, 0);
    stop_req = 1'b0; cyc(3);
    chk("R9 stop flag clear", (rdata >> 6) & 1, 0);
    c0 = cnt; cyc(80);
    chk("R9 counter resumes", (cnt - c0) & 8'hFF, 10);
  endtask

  task automatic t_wrap;
    int prev, seen = 0;
    pin = 1'b1; wr(8'h01); cyc(5);
    prev = cnt;
    for (int i = 0; i < 3000 && seen == 0; i++) begin
      @(negedge clk);
      if (ovf) begin
        seen = 1;
        chk("R10 cnt zero at ovf", cnt, 0);
        chk("R10 prev all-ones", prev, 255);
        @(negedge clk);
        chk("R10 ovf one cycle", ovf, 0);
      end
      prev = cnt;
    end
    chk("R10 ovf seen", seen, 1);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_once();
    for (int p = 0; p < 4; p++) t_gate(p);
    t_gate_low();
    for (int p = 0; p < 4; p++) t_ext(p);
    t_glitch();
    t_phase();
    t_comp(1'b0);
    t_comp(1'b1);
    t_stop();
    t_wrap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule